// File: doc/BRIEF.md
# Multi-Queue Default Setup Sequencer

After a master reset, this block writes the default layout of a multi-queue buffer with no help from software. The layout uses the largest number of queues, `NUM_Q`. It cuts the buffer memory of `DEPTH` words into equal slices and gives each queue a first address and a last address. The sequence waits until the active-low start input is low. It then writes one queue per clock cycle and pulls its active-low done output low.

The done output is meant to drive the start input of the next device. A row of devices therefore sets itself up one device after another. The first device can have its start input tied low. When the done output of the last device falls, the whole system is ready for normal traffic. The queue layout is available on output buses, so the memory and the flag logic can read it.

Top module: `mq_default_setup`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next state is as follows: `cfg_done_n` is 1, and `q_valid`, `q_count` and every `q_base` and `q_last` field are 0.
- R2: While `cfg_en_n` stays high and the sequence has not started, no queue is written (`q_valid` stays 0) and `cfg_done_n` stays 1, however long this lasts.
- R3: The first rising edge that samples `cfg_en_n` low starts the sequence. Each of the next `NUM_Q` edges writes one queue, in order from queue 0 upward. After the k-th of these edges, `q_valid` equals (1<<k)-1, where bit q of `q_valid` belongs to queue q.
- R4: Queue q occupies bits [q*AW +: AW] of `q_base` and of `q_last`, where AW = clog2(`DEPTH`). Its first address is q*`DEPTH`/`NUM_Q`. Its last address is that value plus `DEPTH`/`NUM_Q` - 1.
- R5: `cfg_done_n` falls on the same edge that writes the last queue. That edge is `NUM_Q`+1 edges after the start edge is counted, and `q_valid` is all ones when `cfg_done_n` falls.
- R6: Once `cfg_done_n` is low, it stays low until the next reset, and the layout outputs do not change, whatever `cfg_en_n` does.
- R7: Once started, the sequence runs to the end even if `cfg_en_n` returns high.
- R8: `q_count` is 0 until the sequence finishes and `NUM_Q` afterwards.
- R9: Chain case: a second device whose `cfg_en_n` is driven by the first device's `cfg_done_n` writes nothing while the first is busy. Its `cfg_done_n` falls exactly `NUM_Q`+1 edges after that of the first device.
- R10: A reset in the middle of the sequence clears all progress. After that reset, a new sequence again takes the full R5 timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low master reset |
| cfg_en_n | input | 1 | Active-low start; driven by the previous device's done output or tied low |
| cfg_done_n | output | 1 | Active-low completion; drives the next device's start input |
| q_valid | output | NUM_Q | Bit q is set once queue q has been written |
| q_base | output | NUM_Q*AW | First address of each queue, packed with queue 0 in the low bits |
| q_last | output | NUM_Q*AW | Last address of each queue, packed the same way |
| q_count | output | clog2(NUM_Q+1) | Number of queues configured |

## Verification
Two situations are hard to reach from the ports: a start input that is withdrawn after a single sampled low, and a reset that arrives halfway through the writes. The stimulus changes `cfg_en_n` and `rst_n` on falling edges, so the bench knows exactly which rising edge sees each change. It then follows `q_valid` edge by edge to see whether the sequence goes on or starts over. The chain timing uses a second instance whose start input is wired to the first instance's done output, and the bench counts the edges between the two falls.

// File: rtl/mq_default_setup_pkg.sv
// Package: shared types for the default setup sequencer.
// Assumes nothing beyond IEEE 1800-2017.
package mq_default_setup_pkg;

    // Phases of the default setup sequence
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_LOAD = 2'd1,
        SEQ_DONE = 2'd2
    } seq_state_e;

endpackage

// File: rtl/mq_seq_ctrl.sv
// Module: mq_seq_ctrl
// Waits for the active-low start input, walks a queue index from 0 to
// NUM_Q-1 (one per cycle), then stays in the finished state until reset.
// Assumes NUM_Q >= 2 and a synchronous active-low reset.
module mq_seq_ctrl
    import mq_default_setup_pkg::*;
#(
    parameter int NUM_Q = 4,
    localparam int QW = $clog2(NUM_Q)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_n,
    output seq_state_e        state,
    output logic              wr_en,
    output logic [QW-1:0]     wr_idx,
    output logic              done_n
);

    localparam logic [QW-1:0] LAST_IDX = QW'(NUM_Q - 1);

    // Phase register and queue index walker
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= SEQ_IDLE;
            wr_idx <= '0;
        end else begin
            case (state)
                SEQ_IDLE: begin
                    if (!start_n) begin
                        state  <= SEQ_LOAD;
                        wr_idx <= '0;
                    end
                end
                SEQ_LOAD: begin
                    wr_idx <= wr_idx + 1'b1;
                    if (wr_idx == LAST_IDX) begin
                        state <= SEQ_DONE;
                    end
                end
                default: begin
                    state <= SEQ_DONE;
                end
            endcase
        end
    end

    // Write strobe and completion flag decoded from the phase
    always_comb begin
        wr_en  = (state == SEQ_LOAD);
        done_n = (state != SEQ_DONE);
    end

endmodule

// File: rtl/mq_slice_calc.sv
// Module: mq_slice_calc
// Computes the first and last word address of a queue's equal memory slice.
// Assumes DEPTH is divisible by NUM_Q.
module mq_slice_calc #(
    parameter int DEPTH = 1024,
    parameter int NUM_Q = 4,
    localparam int AW    = $clog2(DEPTH),
    localparam int QW    = $clog2(NUM_Q),
    localparam int SLICE = DEPTH / NUM_Q
) (
    input  logic [QW-1:0] idx,
    output logic [AW-1:0] base,
    output logic [AW-1:0] last
);

    // Slice bounds: idx*SLICE up to idx*SLICE + SLICE - 1
    always_comb begin
        base = AW'(idx) * AW'(SLICE);
        last = base + AW'(SLICE - 1);
    end

endmodule

// File: rtl/mq_setup_regs.sv
// Module: mq_setup_regs
// Holds one base/last/valid entry for each queue; an entry is written when the
// strobe is high and the index selects it. Entries clear on reset.
module mq_setup_regs #(
    parameter int NUM_Q = 4,
    parameter int AW    = 10,
    localparam int QW   = $clog2(NUM_Q)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [QW-1:0]       wr_idx,
    input  logic [AW-1:0]       wr_base,
    input  logic [AW-1:0]       wr_last,
    output logic [NUM_Q-1:0]    valid,
    output logic [NUM_Q*AW-1:0] base_bus,
    output logic [NUM_Q*AW-1:0] last_bus
);

    for (genvar q = 0; q < NUM_Q; q++) begin : g_entry
        logic [AW-1:0] base_r;
        logic [AW-1:0] last_r;
        logic          valid_r;

        // Capture this queue's slice when it is selected
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_r  <= '0;
                last_r  <= '0;
                valid_r <= 1'b0;
            end else if (wr_en && (wr_idx == QW'(q))) begin
                base_r  <= wr_base;
                last_r  <= wr_last;
                valid_r <= 1'b1;
            end
        end

        assign base_bus[q*AW +: AW] = base_r;
        assign last_bus[q*AW +: AW] = last_r;
        assign valid[q]             = valid_r;
    end

endmodule

// File: rtl/mq_default_setup.sv
// Module: mq_default_setup (top)
// Default setup sequencer for a multi-queue buffer. After reset it waits
// for cfg_en_n low, writes NUM_Q equal memory slices one per cycle, then
// drives cfg_done_n low to start the next device of a chain.
// Assumes DEPTH % NUM_Q == 0 and NUM_Q >= 2.
module mq_default_setup
    import mq_default_setup_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int NUM_Q = 4,
    localparam int AW = $clog2(DEPTH),
    localparam int QW = $clog2(NUM_Q),
    localparam int CW = $clog2(NUM_Q + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_en_n,
    output logic                cfg_done_n,
    output logic [NUM_Q-1:0]    q_valid,
    output logic [NUM_Q*AW-1:0] q_base,
    output logic [NUM_Q*AW-1:0] q_last,
    output logic [CW-1:0]       q_count
);

    seq_state_e      seq_state;
    logic            wr_en;
    logic [QW-1:0]   wr_idx;
    logic [AW-1:0]   slice_base;
    logic [AW-1:0]   slice_last;

    mq_seq_ctrl #(.NUM_Q(NUM_Q)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_n (cfg_en_n),
        .state   (seq_state),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .done_n  (cfg_done_n)
    );

    mq_slice_calc #(.DEPTH(DEPTH), .NUM_Q(NUM_Q)) u_calc (
        .idx  (wr_idx),
        .base (slice_base),
        .last (slice_last)
    );

    mq_setup_regs #(.NUM_Q(NUM_Q), .AW(AW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_base  (slice_base),
        .wr_last  (slice_last),
        .valid    (q_valid),
        .base_bus (q_base),
        .last_bus (q_last)
    );

    // Configured queue count: full count once the sequence has finished
    always_comb begin
        q_count = cfg_done_n ? '0 : CW'(NUM_Q);
    end

endmodule

// File: rtl/mq_default_setup_chk.sv
// Module: mq_default_setup_chk
// Protocol checker bound into mq_default_setup.
module mq_default_setup_chk
    import mq_default_setup_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int NUM_Q = 4,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = $clog2(NUM_Q + 1),
    localparam int SLICE = DEPTH / NUM_Q
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cfg_en_n,
    input logic                cfg_done_n,
    input logic [NUM_Q-1:0]    q_valid,
    input logic [NUM_Q*AW-1:0] q_base,
    input logic [NUM_Q*AW-1:0] q_last,
    input logic [CW-1:0]       q_count,
    input seq_state_e          seq_state
);

    // R2: idle with start high writes nothing and stays not-done
    a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == SEQ_IDLE && cfg_en_n) |=> (q_valid == '0 && cfg_done_n));

    // R3: queues fill as a prefix, at most one new queue per cycle
    a_r3_prefix_fill: assert property (@(posedge clk) disable iff (!rst_n)
        ((q_valid & (q_valid + 1'b1)) == '0));
    a_r3_one_per_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones(q_valid) <= $countones($past(q_valid)) + 1));

    // R5 / R8: done implies every queue written and the full count
    a_r5_done_full: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_done_n |-> (&q_valid && q_count == CW'(NUM_Q)));

    // R6: done is sticky and the layout frozen
    a_r6_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_done_n |=> (!cfg_done_n && $stable(q_base) && $stable(q_last)));

    // R4: a written queue holds its slice bounds
    for (genvar q = 0; q < NUM_Q; q++) begin : g_bounds
        a_r4_slice_bounds: assert property (@(posedge clk) disable iff (!rst_n)
            q_valid[q] |-> (q_base[q*AW +: AW] == AW'(q * SLICE) &&
                            q_last[q*AW +: AW] == AW'(q * SLICE + SLICE - 1)));
    end

endmodule

bind mq_default_setup mq_default_setup_chk #(.DEPTH(DEPTH), .NUM_Q(NUM_Q)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_en_n   (cfg_en_n),
    .cfg_done_n (cfg_done_n),
    .q_valid    (q_valid),
    .q_base     (q_base),
    .q_last     (q_last),
    .q_count    (q_count),
    .seq_state  (seq_state)
);

// File: tb/mq_default_setup_bench.sv
// Directed bench for mq_default_setup; a second instance forms a chain.
module mq_default_setup_bench;

    localparam int DEPTH = 1024;
    localparam int NUM_Q = 4;
    localparam int AW    = $clog2(DEPTH);
    localparam int CW    = $clog2(NUM_Q + 1);
    localparam int SLICE = DEPTH / NUM_Q;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_n = 1'b1;
    int   n_checks = 0;
    int   n_errors = 0;
    bit   finished = 1'b0;

    logic                done_a, done_b;
    logic [NUM_Q-1:0]    valid_a, valid_b;
    logic [NUM_Q*AW-1:0] base_a, last_a, base_b, last_b;
    logic [CW-1:0]       cnt_a, cnt_b;

    always #10 clk = ~clk;

    mq_default_setup #(.DEPTH(DEPTH), .NUM_Q(NUM_Q)) u_mq_default_setup (
        .clk(clk), .rst_n(rst_n), .cfg_en_n(en_n), .cfg_done_n(done_a),
        .q_valid(valid_a), .q_base(base_a), .q_last(last_a), .q_count(cnt_a)
    );

    mq_default_setup #(.DEPTH(DEPTH), .NUM_Q(NUM_Q)) u_mq_default_setup_next (
        .clk(clk), .rst_n(rst_n), .cfg_en_n(done_a), .cfg_done_n(done_b),
        .q_valid(valid_b), .q_base(base_b), .q_last(last_b), .q_count(cnt_b)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Advance one rising edge and settle after it
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        en_n  = 1'b1;
        step();
        step();
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // R1: reset state of all outputs
    task automatic t_reset_state();
        do_reset();
        check(done_a === 1'b1, "R1 done_n", 64'(done_a), 64'd1);
        check(valid_a === '0, "R1 q_valid", 64'(valid_a), 64'd0);
        check(cnt_a === '0, "R1 q_count", 64'(cnt_a), 64'd0);
        check(base_a === '0 && last_a === '0, "R1 bounds", 64'(base_a), 64'd0);
    endtask

    // R2: start held high for a long time
    task automatic t_idle_hold();
        do_reset();
        for (int i = 0; i < 30; i++) step();
        check(valid_a === '0, "R2 no writes", 64'(valid_a), 64'd0);
        check(done_a === 1'b1, "R2 done_n high", 64'(done_a), 64'd1);
        check(cnt_a === '0, "R2 q_count", 64'(cnt_a), 64'd0);
    endtask

    // R3 R4 R5 R8 R9: full sequence, edge by edge, with chain observed
    task automatic t_sequence();
        int fall_a;
        int fall_b;
        fall_a = -1;
        fall_b = -1;
        do_reset();
        @(negedge clk);
        en_n = 1'b0;
        for (int k = 1; k <= 2 * (NUM_Q + 1) + 2; k++) begin
            step();
            if (k <= NUM_Q + 1) begin
                logic [NUM_Q-1:0] expv;
                expv = NUM_Q'((1 << (k - 1)) - 1);
                check(valid_a === expv, "R3 fill order", 64'(valid_a), 64'(expv));
                check(done_a === (k != NUM_Q + 1), "R5 done timing",
                      64'(done_a), 64'(k != NUM_Q + 1));
                check(cnt_a === (k == NUM_Q + 1 ? CW'(NUM_Q) : '0), "R8 count",
                      64'(cnt_a), 64'(k == NUM_Q + 1 ? NUM_Q : 0));
                check(valid_b === '0, "R9 next idle", 64'(valid_b), 64'd0);
            end
            if (done_a === 1'b0 && fall_a < 0) fall_a = k;
            if (done_b === 1'b0 && fall_b < 0) fall_b = k;
        end
        for (int q = 0; q < NUM_Q; q++) begin
            check(base_a[q*AW +: AW] === AW'(q * SLICE), "R4 base",
                  64'(base_a[q*AW +: AW]), 64'(q * SLICE));
            check(last_a[q*AW +: AW] === AW'(q * SLICE + SLICE - 1), "R4 last",
                  64'(last_a[q*AW +: AW]), 64'(q * SLICE + SLICE - 1));
            check(base_b[q*AW +: AW] === AW'(q * SLICE), "R9 next base",
                  64'(base_b[q*AW +: AW]), 64'(q * SLICE));
        end
        check(fall_b - fall_a == NUM_Q + 1, "R9 chain gap",
              64'(fall_b - fall_a), 64'(NUM_Q + 1));
        check(cnt_b === CW'(NUM_Q), "R9 next count", 64'(cnt_b), 64'(NUM_Q));
    endtask

    // R6: after done, toggling start changes nothing
    task automatic t_sticky();
        logic [NUM_Q*AW-1:0] snap_b;
        logic [NUM_Q*AW-1:0] snap_l;
        snap_b = base_a;
        snap_l = last_a;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            en_n = i[0];
            step();
            check(done_a === 1'b0, "R6 done stays low", 64'(done_a), 64'd0);
        end
        check(base_a === snap_b && last_a === snap_l, "R6 layout frozen",
              64'(base_a), 64'(snap_b));
        check(valid_a === '1, "R6 valid held", 64'(valid_a), 64'hf);
    endtask

    // R7: start low for a single edge, then high again
    task automatic t_enable_drop();
        do_reset();
        @(negedge clk);
        en_n = 1'b0;
        step();
        @(negedge clk);
        en_n = 1'b1;
        for (int i = 0; i < NUM_Q - 1; i++) step();
        check(done_a === 1'b1, "R7 not yet done", 64'(done_a), 64'd1);
        step();
        check(done_a === 1'b0, "R7 completes", 64'(done_a), 64'd0);
        check(valid_a === '1, "R7 all written", 64'(valid_a), 64'hf);
    endtask

    // R10: reset midway, then a full-length sequence again
    task automatic t_reset_midway();
        do_reset();
        @(negedge clk);
        en_n = 1'b0;
        step();
        step();
        step();
        check(valid_a === NUM_Q'(3), "R10 partial", 64'(valid_a), 64'd3);
        @(negedge clk);
        rst_n = 1'b0;
        step();
        check(valid_a === '0 && done_a === 1'b1, "R10 cleared", 64'(valid_a), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NUM_Q; i++) step();
        check(done_a === 1'b1, "R10 full length", 64'(done_a), 64'd1);
        step();
        check(done_a === 1'b0, "R10 done again", 64'(done_a), 64'd0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    initial begin
        t_reset_state();
        t_idle_hold();
        t_sequence();
        t_sticky();
        t_enable_drop();
        t_reset_midway();
        finish_run();
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule